// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Trap

This block adds or subtracts two 32-bit words that use their two lowest bits as a type tag. A zero tag means a plain small integer. When both tags are zero and the signed result fits in 32 bits, the unit produces the sum or difference and a fresh set of condition codes. Any other case raises a tag-overflow trap instead: either operand carries a nonzero tag, or the operation overflows as signed arithmetic.

The outcome is registered. One clock after an accepted request, a single-cycle `done` strobe appears, together with either a `trap` pulse or a condition-code write strobe `cc_wr`. A trapping operation writes neither the result register nor the flags, so the state it leaves is exactly what the last good operation left. Register-file access and trap vectoring belong to the surrounding pipeline.

Top module: `tagged_arith_unit`

## Requirements
- R1: While reset is applied, and after it, `done`, `trap`, `cc_wr`, `res` and all four flags read zero until the first request completes.
- R2: A request with `req` high is answered with `done` high for exactly one cycle on the next clock edge. `done` stays low in every cycle that follows a cycle without `req`.
- R3: For `sub_sel` = 0 with no trap, `res` becomes `a + b` modulo 2^32.
- R4: For `sub_sel` = 1 with no trap, `res` becomes `a - b` modulo 2^32.
- R5: If bit 0 or bit 1 of either `a` or `b` is 1, the request traps.
- R6: An addition traps when `a[31]` equals `b[31]` and the sum's bit 31 differs from them.
- R7: A subtraction traps when `a[31]` differs from `b[31]` and the difference's bit 31 differs from `a[31]`.
- R8: A trapping request pulses `trap` with `done`, keeps `cc_wr` low, and leaves `res` and all flags at their previous values. A request that does not trap pulses `cc_wr` with `done` and keeps `trap` low.
- R9: On a flag update, `flag_n` is `res[31]` and `flag_z` is 1 exactly when `res` is zero.
- R10: On a flag update, `flag_c` is the carry out of bit 31 for an addition, and the borrow for a subtraction (1 when `a < b` unsigned).
- R11: `flag_v` takes the signed-overflow value on every flag update. A signed overflow always traps, so the value written is 0.
- R12: Cycles without `req` change neither `res` nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block. |
| req | input | 1 | Request strobe. Operands are sampled when it is high. |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract (a - b). |
| a | input | 32 | First tagged operand |
| b | input | 32 | Second tagged operand |
| done | output | 1 | One-cycle completion strobe |
| trap | output | 1 | Tag-overflow trap strobe, aligned with done |
| res | output | 32 | Last non-trapping result |
| cc_wr | output | 1 | Condition-code write strobe, aligned with done |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed-overflow flag |
| flag_c | output | 1 | Carry (add) or borrow (subtract) flag |

## Verification
The assertions check the rules that relate the ports on every cycle:
- the strobe timing;
- that `trap` and `cc_wr` never appear together;
- that a trap or an idle cycle leaves `res` and the flags untouched;
- that a nonzero tag always leads to a trap;
- that N and Z agree with `res` on each flag update and V is written as 0.

The arithmetic values are shown only by the bench's scenarios:
- the exact sums and differences;
- carry against borrow;
- each of the signed-overflow corners;
- the held values after a sequence of traps.

// File: rtl/tau_pkg.sv
package tau_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned TAG_W_DEF  = 2;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;
endpackage

// File: rtl/tau_rst_sync.sv
module tau_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tau_addsub.sv
module tau_addsub #(
  parameter int unsigned W = 32
) (
  input  logic         sub_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry_flag,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff      = sub_sel ? ~b : b;
    wide       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_sel};
    sum        = wide[W-1:0];
    // borrow is the inverse of the carry out when subtracting
    carry_flag = sub_sel ? ~wide[W] : wide[W];
    ovf        = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/tau_tag_check.sv
module tau_tag_check #(
  parameter int unsigned W     = 32,
  parameter int unsigned TAG_W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         tag_err
);
  assign tag_err = |(a[TAG_W-1:0] | b[TAG_W-1:0]);
endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
  import tau_pkg::*;
#(
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned TAG_W       = TAG_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              sub_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              done,
  output logic              trap,
  output logic [DATA_W-1:0] res,
  output logic              cc_wr,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] sum_w;
  logic              carry_w;
  logic              ovf_w;
  logic              tag_err_w;
  logic              trap_cond;

  logic              done_q, done_d;
  logic              trap_q, trap_d;
  logic              ccwr_q, ccwr_d;
  logic [DATA_W-1:0] res_q,  res_d;
  cc_flags_t         cc_q,   cc_d;
  logic              upd_en;

  tau_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tau_addsub #(.W(DATA_W)) u_addsub (
    .sub_sel    (sub_sel),
    .a          (a),
    .b          (b),
    .sum        (sum_w),
    .carry_flag (carry_w),
    .ovf        (ovf_w)
  );

  tau_tag_check #(.W(DATA_W), .TAG_W(TAG_W)) u_tag_check (
    .a       (a),
    .b       (b),
    .tag_err (tag_err_w)
  );

  assign trap_cond = tag_err_w | ovf_w;
  assign upd_en    = req & ~trap_cond;

  // next-state logic
  always_comb begin
    done_d = req;
    trap_d = req & trap_cond;
    ccwr_d = upd_en;
    res_d  = res_q;
    cc_d   = cc_q;
    if (upd_en) begin
      res_d  = sum_w;
      cc_d.n = sum_w[DATA_W-1];
      cc_d.z = (sum_w == '0);
      cc_d.v = ovf_w;
      cc_d.c = carry_w;
    end
  end

  // strobes: written every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      ccwr_q <= 1'b0;
    end else begin
      done_q <= done_d;
      trap_q <= trap_d;
      ccwr_q <= ccwr_d;
    end
  end

  // result and flags: clock-enabled by a non-trapping request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      cc_q  <= '0;
    end else if (upd_en) begin
      res_q <= res_d;
      cc_q  <= cc_d;
    end
  end

  assign done   = done_q;
  assign trap   = trap_q;
  assign cc_wr  = ccwr_q;
  assign res    = res_q;
  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;
endmodule

// File: rtl/tagged_arith_unit_chk.sv
module tagged_arith_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic              done,
  input logic              trap,
  input logic              cc_wr,
  input logic [DATA_W-1:0] res,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);
  // R2
  req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);

  // R2
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);

  // R8
  trap_ccwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && cc_wr));

  // R8
  strobe_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap || cc_wr) |-> done);

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($stable(res) && $stable({flag_n, flag_z, flag_v, flag_c})));

  // R5
  tag_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ((a[TAG_W-1:0] | b[TAG_W-1:0]) != '0)) |=> trap);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_wr |-> (flag_z == (res == '0)));

  // R9
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_wr |-> (flag_n == res[DATA_W-1]));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_wr |-> !flag_v);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(res) && $stable({flag_n, flag_z, flag_v, flag_c})));
endmodule

bind tagged_arith_unit tagged_arith_unit_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .req    (req),
  .a      (a),
  .b      (b),
  .done   (done),
  .trap   (trap),
  .cc_wr  (cc_wr),
  .res    (res),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v),
  .flag_c (flag_c)
);

// File: tb/test_tagged_arith_unit.sv
module test_tagged_arith_unit;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic        sub_sel;
  logic [31:0] a;
  logic [31:0] b;
  logic        done;
  logic        trap;
  logic [31:0] res;
  logic        cc_wr;
  logic        flag_n;
  logic        flag_z;
  logic        flag_v;
  logic        flag_c;

  int total = 0;
  int bad   = 0;

  logic [31:0] held_res;
  logic [3:0]  held_cc;

  // entry: {sub, a, b, trap, res, nzvc}
  localparam int NV = 13;
  localparam logic [101:0] VEC [NV] = '{
    {1'b0, 32'h0000_0004, 32'h0000_0008, 1'b0, 32'h0000_000C, 4'b0000}, // R3
    {1'b0, 32'hFFFF_FFFC, 32'h0000_0004, 1'b0, 32'h0000_0000, 4'b0101}, // R3 R10 carry
    {1'b1, 32'h0000_0008, 32'h0000_0008, 1'b0, 32'h0000_0000, 4'b0100}, // R4
    {1'b1, 32'h0000_0004, 32'h0000_0008, 1'b0, 32'hFFFF_FFFC, 4'b1001}, // R4 R10 borrow
    {1'b0, 32'h7FFF_FFFC, 32'h0000_0004, 1'b1, 32'h0000_0000, 4'b0000}, // R6
    {1'b1, 32'h8000_0000, 32'h0000_0004, 1'b1, 32'h0000_0000, 4'b0000}, // R7
    {1'b0, 32'h0000_0005, 32'h0000_0008, 1'b1, 32'h0000_0000, 4'b0000}, // R5 tag a
    {1'b1, 32'h0000_0008, 32'h0000_0002, 1'b1, 32'h0000_0000, 4'b0000}, // R5 tag b
    {1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, 4'b0000}, // R6 negative
    {1'b1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000, 4'b0000}, // R7 positive
    {1'b0, 32'h8000_0000, 32'h7FFF_FFFC, 1'b0, 32'hFFFF_FFFC, 4'b1000}, // R3 R9
    {1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 4'b0100}, // R4 R9
    {1'b1, 32'h0000_0000, 32'h0000_0004, 1'b0, 32'hFFFF_FFFC, 4'b1001}  // R4 R10
  };

  tagged_arith_unit i_tagged_arith_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .sub_sel(sub_sel), .a(a), .b(b),
    .done(done), .trap(trap), .res(res), .cc_wr(cc_wr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [31:0] x, input logic [31:0] y);
    req = 1'b1; sub_sel = s; a = x; b = y;
  endtask

  task automatic check_outcome(input logic etrap, input logic [31:0] eres, input logic [3:0] ecc);
    check("R2 done", {31'b0, done}, 32'd1);
    check("R8 trap", {31'b0, trap}, {31'b0, etrap});
    check("R8 cc_wr", {31'b0, cc_wr}, {31'b0, ~etrap});
    if (etrap) begin
      check("R8 res held", res, held_res);
      check("R8 flags held", {28'b0, flag_n, flag_z, flag_v, flag_c}, {28'b0, held_cc});
    end else begin
      check("R3/R4 res", res, eres);
      check("R9/R10/R11 flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, {28'b0, ecc});
      held_res = eres;
      held_cc  = ecc;
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; sub_sel = 1'b0; a = '0; b = '0;
    held_res = '0; held_cc = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 res", res, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check("R1 outputs", {26'b0, done, trap, cc_wr, flag_n, flag_z, flag_c}, 32'd0);
    check("R1 res after", res, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][101], VEC[i][100:69], VEC[i][68:37]);
      @(negedge clk);
      req = 1'b0;
      check_outcome(VEC[i][36], VEC[i][35:4], VEC[i][3:0]);
      @(negedge clk);
      // R2 single-cycle strobe
      check("R2 done drop", {29'b0, done, trap, cc_wr}, 32'd0);
    end

    // R12 idle cycles leave state alone
    a = 32'h1234_5678; b = 32'h0000_0004; sub_sel = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 res idle", res, held_res);
    check("R12 flags idle", {28'b0, flag_n, flag_z, flag_v, flag_c}, {28'b0, held_cc});

    // R2 back-to-back requests, then a trap between good ones (R8)
    drive(1'b0, 32'h0000_0010, 32'h0000_0020);
    @(negedge clk);
    check_outcome(1'b0, 32'h0000_0030, 4'b0000);
    drive(1'b0, 32'h0000_0011, 32'h0000_0020);
    @(negedge clk);
    check_outcome(1'b1, 32'h0, 4'b0);
    drive(1'b1, 32'h0000_0010, 32'h0000_0020);
    @(negedge clk);
    req = 1'b0;
    check_outcome(1'b0, 32'hFFFF_FFF0, 4'b1001);
    @(negedge clk);
    check("R2 done after burst", {31'b0, done}, 32'd0);

    // R1 reset asserted mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 async clear res", res, 32'd0);
    check("R1 async clear flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule